// File: doc/BRIEF.md
# Voltage-Regulator Bus Frame CRC and Response Checker

This block handles the 32-bit frames exchanged with a voltage regulator over a serial management bus. It has two independent paths. The command path is combinational: it takes a command word, keeps its upper 29 bits and puts a 3-bit CRC in the bottom three bits, so the frame is ready to shift out. The response path is registered: when a captured response is strobed in, the block checks its CRC and then its acknowledge field, and reports one of three outcomes.

On a good response the block extracts the 16-bit reading, which is a voltage, a current or a status word, and it decodes the two status flags. Every check that is not good increments a consecutive-failure counter, and a good check clears it. The counter stops at a limit that the caller supplies, and a flag is raised while the counter is at or above that limit. The caller can use this flag to decide when to stop retrying and report a fault.

Bit numbering below is by hardware index, with bit 31 as the most significant bit and the first bit on the wire.

Top module: `avs_frame_checker`

## Requirements
- R1: `cmd_frame_o` equals `cmd_word_i[31:3]` in bits 31:3, with the CRC of those 29 bits in bits 2:0. This path is combinational, so it follows the input in the same cycle.
- R2: The CRC is the remainder of MSB-first long division by the polynomial x^3+x+1 (divisor binary 1011). The dividend is bits 31:3 of the frame with three zero bits appended.
- R3: A cycle with `check_i` high gives `result_valid_o` high for exactly the following cycle. In that cycle `result_o` holds the outcome: 00 good, 01 CRC error, 10 no action. The code 11 never appears.
- R4: When `rsp_frame_i[2:0]` differs from the CRC computed over `rsp_frame_i[31:3]`, the outcome is 01, whatever the acknowledge bits hold.
- R5: When the CRC matches and the acknowledge field `rsp_frame_i[31:30]` is not 00, the outcome is 10.
- R6: When the outcome is good, `value_o` takes `rsp_frame_i[23:8]` in the same cycle that the outcome becomes valid. Any other outcome leaves `value_o` unchanged.
- R7: `vdone_o` follows `value_o[15]` and `pwr_warn_o` follows `value_o[11]`. These are the done flag and the over-power warning of a status reading.
- R8: `fail_cnt_o` increments on each outcome of 01 or 10 and clears to 0 on an outcome of 00. It does not increment once it has reached `fail_limit_i`.
- R9: `fail_hit_o` is high exactly while `fail_cnt_o` is greater than or equal to `fail_limit_i`.
- R10: While reset is low and right after it, `result_valid_o` is 0, `result_o` is 00, `value_o` is 0 and `fail_cnt_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_word_i | input | 32 | Command word; bits 2:0 are ignored |
| cmd_frame_o | output | 32 | Command with its CRC in bits 2:0 |
| rsp_frame_i | input | 32 | Captured response frame |
| check_i | input | 1 | Strobe that checks `rsp_frame_i` |
| fail_limit_i | input | CNT_W | Saturation limit for the failure counter |
| result_valid_o | output | 1 | High for one cycle after `check_i` |
| result_o | output | 2 | Outcome code |
| value_o | output | 16 | Last good reading |
| vdone_o | output | 1 | Done flag of the status reading |
| pwr_warn_o | output | 1 | Over-power warning of the status reading |
| fail_cnt_o | output | CNT_W | Consecutive-failure count |
| fail_hit_o | output | 1 | Count is at or above the limit |

## Verification
The hardest case to reach is a frame with both a bad CRC and a nonzero acknowledge. That frame must be classified as a CRC error and not as no action. The bench builds such frames from a correct response and flips the CRC bits. Reaching saturation takes a run of failures with no good frame in between. The bench sends more failures than the limit allows, then lowers the limit below the current count, and then sends a good frame. This shows that the counter stops at the limit, that the flag follows the limit, and that a good frame clears both.

// File: rtl/avs_frame_checker.sv
module avs_frame_checker #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [31:0]      cmd_word_i,
  output logic [31:0]      cmd_frame_o,
  input  logic [31:0]      rsp_frame_i,
  input  logic             check_i,
  input  logic [CNT_W-1:0] fail_limit_i,
  output logic             result_valid_o,
  output logic [1:0]       result_o,
  output logic [15:0]      value_o,
  output logic             vdone_o,
  output logic             pwr_warn_o,
  output logic [CNT_W-1:0] fail_cnt_o,
  output logic             fail_hit_o
);
  localparam logic [1:0] RES_GOOD  = 2'b00;
  localparam logic [1:0] RES_CRC   = 2'b01;
  localparam logic [1:0] RES_NOACT = 2'b10;

  function automatic logic [2:0] crc3(input logic [28:0] d);
    logic [2:0] r;
    logic       fb;
    r = 3'b000;
    for (int i = 28; i >= 0; i--) begin
      fb = r[2] ^ d[i];
      r  = {r[1], r[0] ^ fb, fb};
    end
    return r;
  endfunction

  assign cmd_frame_o = {cmd_word_i[31:3], crc3(cmd_word_i[31:3])};

  logic       crc_ok;
  logic [1:0] outcome;
  assign crc_ok  = (crc3(rsp_frame_i[31:3]) == rsp_frame_i[2:0]);
  assign outcome = !crc_ok                     ? RES_CRC   :
                   (rsp_frame_i[31:30] != 2'b00) ? RES_NOACT : RES_GOOD;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result_valid_o <= 1'b0;
      result_o       <= RES_GOOD;
      value_o        <= '0;
      fail_cnt_o     <= '0;
    end else begin
      result_valid_o <= check_i;
      if (check_i) begin
        result_o <= outcome;
        if (outcome == RES_GOOD) begin
          value_o    <= rsp_frame_i[23:8];
          fail_cnt_o <= '0;
        end else if (fail_cnt_o < fail_limit_i) begin
          fail_cnt_o <= fail_cnt_o + 1'b1;
        end
      end
    end
  end

  assign vdone_o    = value_o[15];
  assign pwr_warn_o = value_o[11];
  assign fail_hit_o = (fail_cnt_o >= fail_limit_i);
endmodule

module avs_frame_checker_sva #(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             check_i,
  input logic [CNT_W-1:0] fail_limit_i,
  input logic             result_valid_o,
  input logic [1:0]       result_o,
  input logic [15:0]      value_o,
  input logic [CNT_W-1:0] fail_cnt_o
);
  a_r3_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    check_i |=> result_valid_o);
  a_r3_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    !check_i |=> !result_valid_o);
  a_r3_no_code11: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid_o |-> result_o != 2'b11);
  a_r6_value_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (result_valid_o && result_o != 2'b00) |-> value_o == $past(value_o));
  a_r8_clear_on_good: assert property (@(posedge clk) disable iff (!rst_n)
    (result_valid_o && result_o == 2'b00) |-> fail_cnt_o == '0);
  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(fail_cnt_o >= fail_limit_i) && $stable(fail_limit_i) && result_valid_o && result_o != 2'b00)
      |-> fail_cnt_o == $past(fail_cnt_o));
endmodule

bind avs_frame_checker avs_frame_checker_sva #(.CNT_W(CNT_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .check_i(check_i), .fail_limit_i(fail_limit_i),
  .result_valid_o(result_valid_o), .result_o(result_o), .value_o(value_o),
  .fail_cnt_o(fail_cnt_o)
);

// File: tb/avs_frame_checker_tb_top.sv
`timescale 1ns/1ps
module avs_frame_checker_tb_top;
  localparam int CW = 4;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [31:0] cmd_word = '0, cmd_frame, rsp = '0;
  logic check = 1'b0;
  logic [CW-1:0] limit = 4'd3;
  logic rv, vdone, warn, hit;
  logic [1:0] res;
  logic [15:0] val;
  logic [CW-1:0] cnt;
  int n_chk = 0, n_ok = 0;
  bit done = 0;

  always #4 clk = ~clk;

  avs_frame_checker #(.CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_word_i(cmd_word), .cmd_frame_o(cmd_frame),
    .rsp_frame_i(rsp), .check_i(check), .fail_limit_i(limit),
    .result_valid_o(rv), .result_o(res), .value_o(val), .vdone_o(vdone),
    .pwr_warn_o(warn), .fail_cnt_o(cnt), .fail_hit_o(hit));

  function automatic logic [2:0] ref_crc(input logic [31:0] f);
    logic [31:0] v;
    v = {f[31:3], 3'b000};
    for (int i = 31; i >= 3; i--)
      if (v[i]) v = v ^ (32'hB << (i - 3));
    return v[2:0];
  endfunction

  function automatic logic [31:0] mk_rsp(input logic [1:0] ack, input logic [4:0] st, input logic [15:0] v);
    logic [31:0] f;
    f = {ack, 1'b0, st, v, 5'h1F, 3'b000};
    return {f[31:3], ref_crc(f)};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act === exp) n_ok++;
    else $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
  endtask

  task automatic send(input logic [31:0] f);
    @(negedge clk); rsp = f; check = 1'b1;
    @(negedge clk); check = 1'b0;
  endtask

  task automatic t_reset();
    chk("R10 valid", {31'b0, rv}, 0);
    chk("R10 result", {30'b0, res}, 0);
    chk("R10 value", {16'b0, val}, 0);
    chk("R10 count", {28'b0, cnt}, 0);
    chk("R9 hit at reset", {31'b0, hit}, 0);
  endtask

  task automatic t_cmd();
    logic [31:0] pats[4] = '{32'h777FFFF8, 32'h7007FFF8, 32'hFFFFFFFF, 32'h0000000F};
    foreach (pats[i]) begin
      @(negedge clk); cmd_word = pats[i]; #1;
      chk("R1 R2 cmd frame", cmd_frame, {pats[i][31:3], ref_crc(pats[i])});
    end
  endtask

  task automatic t_good();
    send(mk_rsp(2'b00, 5'h03, 16'h8800));
    chk("R3 valid", {31'b0, rv}, 1);
    chk("R3 good code", {30'b0, res}, 0);
    chk("R6 value", {16'b0, val}, 32'h8800);
    chk("R7 vdone", {31'b0, vdone}, 1);
    chk("R7 warn", {31'b0, warn}, 1);
    @(negedge clk);
    chk("R3 one-cycle valid", {31'b0, rv}, 0);
    send(mk_rsp(2'b00, 5'h00, 16'h0123));
    chk("R6 value 2", {16'b0, val}, 32'h0123);
    chk("R7 flags clear", {30'b0, vdone, warn}, 0);
  endtask

  task automatic t_errors();
    send(mk_rsp(2'b11, 5'h00, 16'hBEEF) ^ 32'h5);
    chk("R4 crc err over bad ack", {30'b0, res}, 1);
    chk("R6 hold on crc err", {16'b0, val}, 32'h0123);
    chk("R8 count 1", {28'b0, cnt}, 1);
    send(mk_rsp(2'b01, 5'h00, 16'hBEEF));
    chk("R5 noaction", {30'b0, res}, 2);
    chk("R6 hold on noaction", {16'b0, val}, 32'h0123);
    send(mk_rsp(2'b00, 5'h00, 16'h4444) ^ 32'h1);
    chk("R4 crc err good ack", {30'b0, res}, 1);
    chk("R8 count 3", {28'b0, cnt}, 3);
    chk("R9 hit at limit", {31'b0, hit}, 1);
    send(mk_rsp(2'b10, 5'h00, 16'h0));
    chk("R8 saturated", {28'b0, cnt}, 3);
    @(negedge clk); limit = 4'd2; #1;
    chk("R9 hit above limit", {31'b0, hit}, 1);
    limit = 4'd5; #1;
    chk("R9 hit below limit", {31'b0, hit}, 0);
    send(mk_rsp(2'b00, 5'h1F, 16'h0800));
    chk("R8 clear on good", {28'b0, cnt}, 0);
    chk("R7 warn only", {30'b0, vdone, warn}, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cmd();
    t_good();
    t_errors();
    done = 1;
    $display("%0d/%0d checks passed", n_ok, n_chk);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_chk++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_ok, n_chk);
      $finish;
    end
  end
endmodule